// File: doc/BRIEF.md
# Dirty-Block Scrub Trigger

This unit sits beside one cache bank that keeps its least-recently-used ways as an in-cache write buffer. Each cycle it compares the bank's dirty-block figures against thresholds and tells a separate scrubber when to start writing dirty blocks back to DRAM and when to back off. It does not count dirty blocks and it does not scrub. Both counts arrive from elsewhere, already maintained.

There are two threshold tests. The first is a bank-wide high-water test on the dirty population inside the reserved ways. The second counts sets whose reserved ways are all dirty, and it applies only when the dirty population also clears a lower floor. The floor keeps the scrubber from starting when there are too few blocks to choose from. Every threshold is a product of the set count N, the reserved width n and an 8-bit fraction in units of 1/256. All compares are done by multiplying, with no division. The thresholds are registered when a new width is loaded.

Separately, any DRAM channel with no pending reads starts a scrub on its own. A read arriving on a channel while a scrub runs raises a one-cycle stop request. The start request is a level. It stays high until the scrubber reports completion or a stop occurs.

Top module: `scrub_trigger`

## Requirements
- R1: After reset, scrub_start and scrub_stop are 0. Before the first cycle with cfg_load high, neither threshold test can start a scrub, whatever the counts are.
- R2: On a clock edge with cfg_load high, the unit registers N·n·hwm_frac, N·n·low_frac and N·full_frac from the inputs present at that edge. Changes to set_count, wb_ways or any fraction in cycles without cfg_load have no effect on the outputs.
- R3: The high-water test holds when dirty_pop·256 ≥ N·n·hwm_frac.
- R4: The overfull test holds when full_sets·256 ≥ N·full_frac and also dirty_pop·256 ≥ N·n·low_frac. Failing either half means the test does not hold.
- R5: A 0 in any bit of ch_read_pending (channel i has no reads waiting) is a start condition, with or without a threshold test.
- R6: scrub_start is a level. Once high, it stays high until a clock edge where scrub_done is 1 or a read arrives. scrub_done has no effect while scrub_start is low.
- R7: A read arrives on a channel when its ch_read_pending bit goes from 0 to 1 between two edges. If scrub_start is high at that edge, the edge sets scrub_stop to 1 for exactly one cycle and clears scrub_start.
- R8: scrub_start goes high on the first clock edge at which it is low and a start condition (R3, R4 or R5) holds, using the thresholds registered before that edge.
- R9: After scrub_start falls, the conditions are evaluated again at the next edge. A scrub restarts one cycle later if a start condition still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Register a new width and its thresholds |
| set_count | input | SET_W | Number of sets N in the bank |
| wb_ways | input | WAY_W | Reserved write-buffer width n in ways |
| hwm_frac | input | 8 | High-water fraction, units of 1/256 |
| low_frac | input | 8 | Minimum-population fraction for the overfull test |
| full_frac | input | 8 | Full-set fraction f, units of 1/256 |
| dirty_pop | input | SET_W+WAY_W | Dirty blocks in the reserved ways |
| full_sets | input | SET_W | Sets whose reserved ways are all dirty |
| ch_read_pending | input | NUM_CH | Per channel: 1 when reads are waiting |
| scrub_done | input | 1 | Scrubber finished its passes |
| scrub_start | output | 1 | Scrub request level |
| scrub_stop | output | 1 | One-cycle back-off request |

## Verification
The bench drives dirty_pop exactly at each product threshold and one below it. A compare written with > instead of ≥, or with the fraction scaled wrongly, therefore shows up as a missing or extra start. It also holds the full-set count above its threshold while the population sits one below the floor. A design that drops the minimum-population guard would start a scrub there. Fractions are changed without a load to catch thresholds that follow the live inputs. A channel that goes idle and then receives a read must produce a single stop pulse with start falling on the same edge; a held level or a dropped pulse is reported. A done pulse while idle must leave start low.

// File: rtl/scrub_trig_pkg.sv
// Shared constants for the scrub trigger.
// Assumes every fraction is an unsigned fixed-point value scaled by 2^FRAC_W.
package scrub_trig_pkg;
    localparam int FRAC_W = 8;
endpackage

// File: rtl/scrub_thresh_reg.sv
// Holds the three compare thresholds. They are recomputed from N, n and the
// fractions on a load edge and held at all other times.
// Assumes the products fit the widths derived below, so nothing is truncated.
module scrub_thresh_reg
    import scrub_trig_pkg::*;
#(
    parameter int SET_W = 12,
    parameter int WAY_W = 5,
    localparam int POP_W = SET_W + WAY_W,
    localparam int PTW = POP_W + FRAC_W,
    localparam int FTW = SET_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SET_W-1:0] set_count,
    input  logic [WAY_W-1:0] ways,
    input  logic [FRAC_W-1:0] hwm_frac,
    input  logic [FRAC_W-1:0] low_frac,
    input  logic [FRAC_W-1:0] full_frac,
    output logic [PTW-1:0]   thr_hwm,
    output logic [PTW-1:0]   thr_low,
    output logic [FTW-1:0]   thr_full,
    output logic             cfg_valid
);
    logic [POP_W-1:0] capacity;
    logic [PTW-1:0]   hwm_prod;
    logic [PTW-1:0]   low_prod;
    logic [FTW-1:0]   full_prod;

    // Reserved capacity N*n and the scaled thresholds taken from it.
    always_comb begin
        capacity  = POP_W'(set_count) * POP_W'(ways);
        hwm_prod  = PTW'(capacity) * PTW'(hwm_frac);
        low_prod  = PTW'(capacity) * PTW'(low_frac);
        full_prod = FTW'(set_count) * FTW'(full_frac);
    end

    // Register the thresholds on a load edge; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_hwm   <= '0;
            thr_low   <= '0;
            thr_full  <= '0;
            cfg_valid <= 1'b0;
        end else if (load) begin
            thr_hwm   <= hwm_prod;
            thr_low   <= low_prod;
            thr_full  <= full_prod;
            cfg_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/scrub_crit_eval.sv
// Combinational check of the high-water test and the guarded overfull test.
// Counts are scaled by 2^FRAC_W so that no division is needed.
// Assumes the thresholds come from scrub_thresh_reg; nothing fires until cfg_valid is set.
module scrub_crit_eval
    import scrub_trig_pkg::*;
#(
    parameter int SET_W = 12,
    parameter int WAY_W = 5,
    localparam int POP_W = SET_W + WAY_W,
    localparam int PTW = POP_W + FRAC_W,
    localparam int FTW = SET_W + FRAC_W
) (
    input  logic [POP_W-1:0] dirty_pop,
    input  logic [SET_W-1:0] full_sets,
    input  logic [PTW-1:0]   thr_hwm,
    input  logic [PTW-1:0]   thr_low,
    input  logic [FTW-1:0]   thr_full,
    input  logic             cfg_valid,
    output logic             hit
);
    logic [PTW-1:0] pop_scaled;
    logic [FTW-1:0] full_scaled;
    logic           over_hwm;
    logic           over_full;
    logic           over_low;

    // Scale both counts and compare them against the registered products.
    always_comb begin
        pop_scaled  = {dirty_pop, {FRAC_W{1'b0}}};
        full_scaled = {full_sets, {FRAC_W{1'b0}}};
        over_hwm    = pop_scaled >= thr_hwm;
        over_low    = pop_scaled >= thr_low;
        over_full   = full_scaled >= thr_full;
        hit         = cfg_valid && (over_hwm || (over_full && over_low));
    end
endmodule

// File: rtl/scrub_chan_watch.sv
// Per-channel watch of the pending-read flags. Reports whether any channel is
// idle and whether a read has just arrived on any channel (flag went 0 to 1).
// Assumes the pending flags are synchronous to clk.
module scrub_chan_watch #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pending,
    output logic              any_idle,
    output logic              any_arrival
);
    logic [NUM_CH-1:0] prev_q;
    logic [NUM_CH-1:0] idle_v;
    logic [NUM_CH-1:0] arr_v;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Remember this channel's previous flag.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[ch] <= 1'b0;
            else        prev_q[ch] <= pending[ch];
        end
        assign idle_v[ch] = ~pending[ch];
        assign arr_v[ch]  = pending[ch] & ~prev_q[ch];
    end

    // Reduce the per-channel flags to the two bank-level events.
    always_comb begin
        any_idle    = |idle_v;
        any_arrival = |arr_v;
    end
endmodule

// File: rtl/scrub_ctrl.sv
// Request state machine: a start level and a one-cycle stop pulse.
// Assumes the trigger inputs are valid in every cycle and only act at clock edges.
module scrub_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic crit_hit,
    input  logic any_idle,
    input  logic any_arrival,
    input  logic done,
    output logic start_q,
    output logic stop_q
);
    logic start_d;

    // Next state of the level: clear on done or arrival, set on any trigger.
    always_comb begin
        if (start_q) start_d = !(done || any_arrival);
        else         start_d = crit_hit || any_idle;
    end

    // Register the level and the stop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            start_q <= start_d;
            stop_q  <= start_q && any_arrival;
        end
    end
endmodule

// File: rtl/scrub_trigger.sv
// Top of the scrub trigger. It combines the threshold tests with the per-channel
// idle and arrival events, and drives the start and stop requests to the scrubber.
// Assumes dirty_pop and full_sets are kept up to date by the cache bank.
module scrub_trigger
    import scrub_trig_pkg::*;
#(
    parameter int SET_W  = 12,
    parameter int WAY_W  = 5,
    parameter int NUM_CH = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_load,
    input  logic [SET_W-1:0]       set_count,
    input  logic [WAY_W-1:0]       wb_ways,
    input  logic [FRAC_W-1:0]      hwm_frac,
    input  logic [FRAC_W-1:0]      low_frac,
    input  logic [FRAC_W-1:0]      full_frac,
    input  logic [SET_W+WAY_W-1:0] dirty_pop,
    input  logic [SET_W-1:0]       full_sets,
    input  logic [NUM_CH-1:0]      ch_read_pending,
    input  logic                   scrub_done,
    output logic                   scrub_start,
    output logic                   scrub_stop
);
    localparam int POP_W = SET_W + WAY_W;
    localparam int PTW   = POP_W + FRAC_W;
    localparam int FTW   = SET_W + FRAC_W;

    logic [PTW-1:0] thr_hwm;
    logic [PTW-1:0] thr_low;
    logic [FTW-1:0] thr_full;
    logic           cfg_valid;
    logic           crit_hit;
    logic           any_idle;
    logic           any_arrival;

    scrub_thresh_reg #(.SET_W(SET_W), .WAY_W(WAY_W)) u_thresh (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .set_count(set_count), .ways(wb_ways),
        .hwm_frac(hwm_frac), .low_frac(low_frac), .full_frac(full_frac),
        .thr_hwm(thr_hwm), .thr_low(thr_low), .thr_full(thr_full),
        .cfg_valid(cfg_valid)
    );

    scrub_crit_eval #(.SET_W(SET_W), .WAY_W(WAY_W)) u_crit (
        .dirty_pop(dirty_pop), .full_sets(full_sets),
        .thr_hwm(thr_hwm), .thr_low(thr_low), .thr_full(thr_full),
        .cfg_valid(cfg_valid), .hit(crit_hit)
    );

    scrub_chan_watch #(.NUM_CH(NUM_CH)) u_chan (
        .clk(clk), .rst_n(rst_n), .pending(ch_read_pending),
        .any_idle(any_idle), .any_arrival(any_arrival)
    );

    scrub_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .crit_hit(crit_hit),
        .any_idle(any_idle), .any_arrival(any_arrival), .done(scrub_done),
        .start_q(scrub_start), .stop_q(scrub_stop)
    );
endmodule

// File: rtl/scrub_trigger_chk.sv
// Protocol checks on the request outputs, bound into scrub_trigger.
// Assumes reset is asserted from time zero.
module scrub_trigger_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_read_pending,
    input logic              scrub_done,
    input logic              crit_hit,
    input logic              scrub_start,
    input logic              scrub_stop
);
    AST_STOP_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_stop |-> $past(scrub_start)); // R7
    AST_STOP_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_stop |-> !scrub_start); // R7
    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_stop |=> !scrub_stop); // R7
    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scrub_start) |-> ($past(scrub_done) || scrub_stop)); // R6
    AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scrub_start) |-> ($past(crit_hit) || !$past(&ch_read_pending))); // R8
endmodule

bind scrub_trigger scrub_trigger_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ch_read_pending(ch_read_pending),
    .scrub_done(scrub_done), .crit_hit(crit_hit),
    .scrub_start(scrub_start), .scrub_stop(scrub_stop)
);

// File: tb/test_scrub_trigger.sv
// Self-checking bench: a cycle model built from the requirements, directed
// corner cases, then seeded random traffic.
module test_scrub_trigger;
    localparam int CLK_PERIOD = 10;
    localparam int SET_W  = 12;
    localparam int WAY_W  = 5;
    localparam int NUM_CH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [SET_W-1:0] set_count = '0;
    logic [WAY_W-1:0] wb_ways = '0;
    logic [7:0] hwm_frac = '0, low_frac = '0, full_frac = '0;
    logic [SET_W+WAY_W-1:0] dirty_pop = '0;
    logic [SET_W-1:0] full_sets = '0;
    logic [NUM_CH-1:0] ch_read_pending = '1;
    logic scrub_done = 1'b0;
    logic scrub_start, scrub_stop;

    int n_checks = 0;
    int n_errors = 0;
    longint m_hwm = 0, m_low = 0, m_full = 0;
    bit m_valid = 0, m_act = 0, m_stop = 0;
    logic [NUM_CH-1:0] m_prev = '0;

    scrub_trigger #(.SET_W(SET_W), .WAY_W(WAY_W), .NUM_CH(NUM_CH)) i_scrub_trigger (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .set_count(set_count),
        .wb_ways(wb_ways), .hwm_frac(hwm_frac), .low_frac(low_frac),
        .full_frac(full_frac), .dirty_pop(dirty_pop), .full_sets(full_sets),
        .ch_read_pending(ch_read_pending), .scrub_done(scrub_done),
        .scrub_start(scrub_start), .scrub_stop(scrub_stop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected threshold test from R3 and R4.
    function automatic bit exp_crit();
        longint d = longint'(dirty_pop) * 256;
        longint f = longint'(full_sets) * 256;
        return m_valid && (d >= m_hwm || (f >= m_full && d >= m_low));
    endfunction

    // Model one clock edge from the inputs present at it.
    task automatic model_edge();
        bit arr, idle, crit;
        if (!rst_n) begin
            m_act = 0; m_stop = 0; m_valid = 0; m_prev = '0;
            m_hwm = 0; m_low = 0; m_full = 0;
            return;
        end
        arr  = |(ch_read_pending & ~m_prev);
        idle = |(~ch_read_pending);
        crit = exp_crit();
        m_stop = m_act && arr;
        m_act  = m_act ? !(arr || scrub_done) : (crit || idle);
        if (cfg_load) begin
            m_hwm  = longint'(set_count) * wb_ways * hwm_frac;
            m_low  = longint'(set_count) * wb_ways * low_frac;
            m_full = longint'(set_count) * full_frac;
            m_valid = 1;
        end
        m_prev = ch_read_pending;
    endtask

    // One cycle: the edge, then compare both outputs at the falling edge.
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_checks++;
        if (scrub_start !== m_act || scrub_stop !== m_stop) begin
            n_errors++;
            $display("FAIL %s: start=%0b stop=%0b expected start=%0b stop=%0b",
                     tag, scrub_start, scrub_stop, m_act, m_stop);
        end
    endtask

    task automatic load_cfg(input int n_sets, input int ways, input int h,
                            input int lo, input int f, input string tag);
        set_count = SET_W'(n_sets); wb_ways = WAY_W'(ways);
        hwm_frac = 8'(h); low_frac = 8'(lo); full_frac = 8'(f);
        cfg_load = 1'b1;
        step(tag);
        cfg_load = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int seed = 32'h5C2B;
        void'($urandom(seed));
        @(negedge clk);
        // R1: outputs low during reset.
        repeat (3) step("R1");
        rst_n = 1'b1;
        // R1: no threshold trigger before the first load.
        dirty_pop = '1; full_sets = '1;
        repeat (3) step("R1");
        dirty_pop = '0; full_sets = '0;
        // Thresholds: dirty >= 200 (hwm), dirty >= 100 (low), full >= 25.
        load_cfg(100, 4, 128, 64, 64, "R2");
        dirty_pop = 199; step("R3");
        dirty_pop = 200; step("R8");
        step("R6");
        scrub_done = 1'b1; step("R6");
        scrub_done = 1'b0; step("R9");
        dirty_pop = 0; scrub_done = 1'b1; step("R6");
        scrub_done = 1'b0; step("R6");
        full_sets = 25; dirty_pop = 100; step("R4");
        scrub_done = 1'b1; dirty_pop = 99; step("R4");
        scrub_done = 1'b0; step("R4");
        full_sets = 24; dirty_pop = 150; step("R4");
        // R2: new fractions without a load have no effect.
        hwm_frac = 1; full_frac = 0; step("R2");
        step("R2");
        load_cfg(100, 4, 1, 64, 64, "R2");
        step("R2");
        scrub_done = 1'b1; dirty_pop = 0; full_sets = 0; step("R6");
        scrub_done = 1'b0; step("R6");
        // R5 / R7: idle channel starts, read arrival stops.
        ch_read_pending = 2'b10; step("R5");
        step("R6");
        ch_read_pending = 2'b11; step("R7");
        step("R7");
        scrub_done = 1'b1; step("R6");
        scrub_done = 1'b0;
        ch_read_pending = 2'b01; step("R5");
        ch_read_pending = 2'b11; step("R7");
        // Seeded random traffic against the model.
        for (int i = 0; i < 4000; i++) begin
            cfg_load = ($urandom % 20) == 0;
            if (cfg_load) begin
                set_count = SET_W'(1 + $urandom % 63);
                wb_ways   = WAY_W'(3 + $urandom % 14);
                hwm_frac  = 8'($urandom); low_frac = 8'($urandom);
                full_frac = 8'($urandom);
            end
            dirty_pop = (SET_W+WAY_W)'($urandom % (set_count * wb_ways + 1));
            full_sets = SET_W'($urandom % (set_count + 1));
            ch_read_pending = (($urandom % 8) == 0) ? NUM_CH'($urandom) : '1;
            scrub_done = ($urandom % 10) == 0;
            step("R8");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule